// File: doc/BRIEF.md
# Converter Register Access Serial Master

This block carries out single register writes and reads on a multichannel data converter whose configuration is reached over a four-wire serial link in software-control mode. A host places a 16-bit command word on `cmd_i`, with the register address in bits 13:8 and the value in bits 7:0. It then pulses `wr_req_i` or `rd_req_i` for one cycle. The block turns that into a 16-bit frame, lowers chip select, produces a divided serial clock and shifts the frame out on the converter's data-input line.

The link uses SPI mode 3. The clock rests high, outgoing data moves on falling edges and incoming data is taken on rising edges. A read returns its byte on the converter's first conversion-data output, not on a dedicated return pin. The block gathers the eight bits clocked in during the payload field and presents them with a single-cycle strobe when chip select goes back high. While a transfer is in flight, `busy_o` is high and new requests are dropped.

Top module: `adc_reg_spi_master`

## Requirements
- R1: A frame is 16 bits, sent MSB first: bit 15 is always 0, bit 14 is 1 for a read and 0 for a write, bits 13:8 hold the 6-bit address, and bits 7:0 hold the write value (all zeros for a read). No CRC field is appended, so writing 0x23 to register 0x01 sends 0x0123.
- R2: The address comes from `cmd_i[13:8]` and the value from `cmd_i[7:0]`. `cmd_i[15:14]` has no effect, and a read ignores `cmd_i[7:0]`.
- R3: When `wr_req_i` and `rd_req_i` are both high at an accepted edge, the block performs a write.
- R4: Clocking follows SPI mode 3. `sclk_o` is high whenever `cs_no` is high. `sdi_o` changes only at the edge that lowers `cs_no` or on a falling edge of `sclk_o`, and it never changes on a rising edge.
- R5: Each half period of `sclk_o` lasts `div_i` system clocks. The value is latched when the request is accepted, and a value of 0 selects the default of 20.
- R6: `cs_no` falls on the edge that accepts a request, with `sclk_o` high. One half period later the first falling edge occurs. Exactly 16 rising edges follow, then one further high half period, after which `cs_no` returns high (33 half periods in all).
- R7: `busy_o` is high from the accepting edge until the edge that raises `cs_no`. A request seen while `busy_o` is high is ignored, and a request on the edge after `busy_o` falls is accepted.
- R8: On a read, `dout_a_i` is sampled at the 9th through 16th rising edges. The bits are assembled MSB first into `rd_data_o`, and `rd_valid_o` is high for exactly one cycle, on the edge that raises `cs_no`. `rd_data_o` holds its value until the next read completes.
- R9: A write never asserts `rd_valid_o`.
- R10: After reset, `cs_no`=1, `sclk_o`=1, `sdi_o`=0, `busy_o`=0, `rd_valid_o`=0 and `rd_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Register write request pulse |
| rd_req_i | input | 1 | Register read request pulse |
| cmd_i | input | 16 | Command word: address in 13:8, value in 7:0 |
| div_i | input | 8 | Half-period length in system clocks (0 selects 20) |
| busy_o | output | 1 | Transfer in progress |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdi_o | output | 1 | Serial data to the converter |
| dout_a_i | input | 1 | Converter data output carrying read-back bits |
| rd_data_o | output | 8 | Last register value read |
| rd_valid_o | output | 1 | One-cycle strobe for a completed read |

## Verification
A divider count that slips or reloads wrongly stretches or shrinks a half period. That shows on `sclk_o` at the very next expected toggle, and the bench compares every clock, so it is caught within a single half period. A phase counter that is off by one moves the data transitions onto a rising edge or shifts the frame by a bit, and this shows on `sdi_o` within two half periods of the fault. A capture register that samples on the wrong edge or the wrong window only reveals itself in `rd_data_o` at the end of the read. The slave model therefore drives distinct values outside the payload window, so a mis-sampled bit changes the returned byte.

// File: rtl/adc_reg_pkg.sv
package adc_reg_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int LAST_PH = 2 * FRAME_W;           // guard half period index
  localparam int PH_W    = $clog2(LAST_PH + 1);

  function automatic logic [FRAME_W-1:0] make_frame(input logic is_rd,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] val);
    logic [DATA_W-1:0] payload;
    payload = is_rd ? '0 : val;
    return {1'b0, is_rd, addr, payload};
  endfunction
endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 20
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          run_i,
  input  logic [DIV_W-1:0]              div_i,
  output logic                          tick_o,
  output logic [adc_reg_pkg::PH_W-1:0]  ph_o
);
  import adc_reg_pkg::*;

  logic [DIV_W-1:0] div_q, cnt_q, div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(DEF_DIV) : div_i;
  assign tick_o  = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
      ph_o  <= '0;
    end else if (start_i) begin
      div_q <= div_eff;
      cnt_q <= div_eff - 1'b1;
      ph_o  <= '0;
    end else if (tick_o) begin
      cnt_q <= div_q - 1'b1;
      ph_o  <= ph_o + 1'b1;
    end else if (run_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [adc_reg_pkg::FRAME_W-1:0]    frame_i,
  input  logic                               tick_i,
  input  logic [adc_reg_pkg::PH_W-1:0]       ph_i,
  output logic                               cs_no,
  output logic                               sclk_o,
  output logic                               sdi_o
);
  import adc_reg_pkg::*;

  logic [FRAME_W-1:0] sh_q;

  assign sdi_o = sh_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cs_no  <= 1'b1;
      sclk_o <= 1'b1;
    end else if (start_i) begin
      sh_q   <= frame_i;
      cs_no  <= 1'b0;
      sclk_o <= 1'b1;
    end else if (tick_i) begin
      if (ph_i == PH_W'(LAST_PH)) begin
        cs_no  <= 1'b1;
        sclk_o <= 1'b1;
        sh_q   <= '0;
      end else if (!ph_i[0]) begin
        sclk_o <= 1'b0;                     // falling edge: launch next bit
        if (ph_i != '0) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end else begin
        sclk_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick_i,
  input  logic [adc_reg_pkg::PH_W-1:0]      ph_i,
  input  logic                              done_i,
  input  logic                              is_rd_i,
  input  logic                              dout_i,
  output logic [adc_reg_pkg::DATA_W-1:0]    rd_data_o,
  output logic                              rd_valid_o
);
  import adc_reg_pkg::*;

  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q       <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      // rising edge ends each odd half period; last DATA_W samples are payload
      if (tick_i && ph_i[0]) rx_q <= {rx_q[DATA_W-2:0], dout_i};
      rd_valid_o <= done_i && is_rd_i;
      if (done_i && is_rd_i) rd_data_o <= rx_q;
    end
  end
endmodule

// File: rtl/adc_reg_spi_master.sv
module adc_reg_spi_master #(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic             rd_req_i,
  input  logic [15:0]      cmd_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             sdi_o,
  input  logic             dout_a_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o
);
  import adc_reg_pkg::*;

  logic            start, tick, done, is_rd_q, req_rd;
  logic [PH_W-1:0] ph;
  logic [FRAME_W-1:0] frame;

  assign start  = !busy_o && (wr_req_i || rd_req_i);
  assign req_rd = !wr_req_i;                          // write wins a tie
  assign done   = tick && (ph == PH_W'(LAST_PH));
  assign frame  = make_frame(req_rd, cmd_i[ADDR_W+DATA_W-1:DATA_W], cmd_i[DATA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      is_rd_q <= 1'b0;
    end else if (start) begin
      busy_o  <= 1'b1;
      is_rd_q <= req_rd;
    end else if (done) begin
      busy_o  <= 1'b0;
    end
  end

  adc_half_timer #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_timer (
    .clk_i, .rst_ni, .start_i(start), .run_i(busy_o), .div_i,
    .tick_o(tick), .ph_o(ph)
  );

  adc_frame_tx i_tx (
    .clk_i, .rst_ni, .start_i(start), .frame_i(frame), .tick_i(tick), .ph_i(ph),
    .cs_no, .sclk_o, .sdi_o
  );

  adc_rd_capture i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .ph_i(ph), .done_i(done), .is_rd_i(is_rd_q),
    .dout_i(dout_a_i), .rd_data_o, .rd_valid_o
  );
endmodule

// File: rtl/adc_reg_spi_master_chk.sv
module adc_reg_spi_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic cs_no,
  input logic sclk_o,
  input logic sdi_o,
  input logic rd_valid_o
);
  AST_CLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o); // R4
  AST_SDI_HOLD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdi_o)); // R4
  AST_CS_FALL_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> sclk_o); // R6
  AST_BUSY_TRACKS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_no); // R7
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $rose(cs_no)); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R8
endmodule

bind adc_reg_spi_master adc_reg_spi_master_chk i_chk (
  .clk_i, .rst_ni, .busy_o, .cs_no, .sclk_o, .sdi_o, .rd_valid_o
);

// File: tb/test_adc_reg_spi_master.sv
`timescale 1ns/1ps
module test_adc_reg_spi_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, dout_a = 1'b0;
  logic [15:0] cmd = '0;
  logic [7:0]  div = 8'd2;
  logic busy, cs_n, sclk, sdi, rd_valid;
  logic [7:0] rd_data;
  logic [7:0] slv_byte = 8'h00;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_reg_spi_master i_adc_reg_spi_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .rd_req_i(rd_req),
    .cmd_i(cmd), .div_i(div), .busy_o(busy), .cs_no(cs_n), .sclk_o(sclk),
    .sdi_o(sdi), .dout_a_i(dout_a), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // converter model: launches a bit on each falling clock, 1s outside the payload
  initial begin
    int falls = 0;
    forever begin
      @(negedge sclk or posedge cs_n);
      if (cs_n) falls = 0;
      else begin
        falls++;
        dout_a = (falls >= 9 && falls <= 16) ? slv_byte[16 - falls] : 1'b1;
      end
    end
  end

  // reference model, stepped at each falling clk for the preceding rising edge
  bit m_act = 0, m_rd = 0, p_wr = 0, p_rd = 0, e_valid = 0;
  int m_j = 0, m_d = 20;
  logic [15:0] m_frame = '0, p_cmd = '0;
  logic [7:0]  p_div = '0, m_byte = '0, e_data = '0;
  int reads_seen = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        e_valid = 0;
        if (m_act) begin
          m_j++;
          if (m_j == 33 * m_d) begin
            m_act = 0;
            if (m_rd) begin e_valid = 1; e_data = m_byte; end
          end
        end else if (p_wr || p_rd) begin
          m_act = 1; m_j = 0;
          m_d = (p_div == 0) ? 20 : int'(p_div);
          m_rd = !p_wr;                                   // R3 write wins
          m_frame = {1'b0, m_rd, p_cmd[13:8], m_rd ? 8'h00 : p_cmd[7:0]}; // R1 R2
          m_byte = slv_byte;
        end
        begin
          int h, idx;
          h = m_j / m_d;
          idx = (h == 0) ? 0 : (h - 1) / 2;
          check("R7", "busy", busy, m_act);
          check("R6", "cs_n", cs_n, !m_act);
          check("R4", "sclk", sclk, m_act ? ((h % 2 == 1) ? 0 : 1) : 1);
          check("R1", "sdi", sdi, m_act ? m_frame[15 - idx] : 0);
          check("R8", "rd_valid", rd_valid, e_valid);
          if (e_valid) begin
            check("R8", "rd_data", rd_data, e_data);
            reads_seen++;
          end
        end
      end
      p_wr = wr_req; p_rd = rd_req; p_cmd = cmd; p_div = div;
    end
  end

  task automatic issue(input bit w, input bit r, input logic [15:0] c, input logic [7:0] d);
    @(posedge clk); #2;
    wr_req = w; rd_req = r; cmd = c; div = d;
    @(posedge clk); #2;
    wr_req = 0; rd_req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "cs_n", cs_n, 1); check("R10", "sclk", sclk, 1);
    check("R10", "sdi", sdi, 0);   check("R10", "busy", busy, 0);
    check("R10", "rd_valid", rd_valid, 0); check("R10", "rd_data", rd_data, 0);
    rst_n = 1'b1;

    // R1: 0x23 to register 0x01 -> 0x0123 on the line
    issue(1, 0, 16'h0123, 8'd2);
    @(posedge clk); #2 div = 8'd7;                 // R5 latched value used
    wait_idle();
    check("R9", "no valid after write", rd_valid, 0);

    // R2: upper bits ignored
    issue(1, 0, 16'hC0A5, 8'd1);
    wait_idle();

    // R3: both requests -> write
    issue(1, 1, 16'h3F5A, 8'd3);
    wait_idle();

    // R8: read with default divider (R5)
    slv_byte = 8'hB4;
    issue(0, 1, 16'h15FF, 8'd0);
    wait_idle();
    check("R8", "read byte held", rd_data, 8'hB4);

    // R7: request while busy is ignored
    slv_byte = 8'h3C;
    issue(0, 1, 16'h2A00, 8'd1);
    repeat (5) @(posedge clk);
    #2 wr_req = 1; cmd = 16'h0777;
    @(posedge clk); #2 wr_req = 0;
    wait_idle();
    check("R8", "rd_data after ignored write", rd_data, 8'h3C);

    // R7: back-to-back, request on the edge after busy falls
    slv_byte = 8'h81;
    issue(0, 1, 16'h0100, 8'd1);
    @(negedge clk);
    while (busy) @(negedge clk);
    issue(1, 0, 16'h0200, 8'd2);
    wait_idle();
    check("R8", "read count", reads_seen, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule